// File: doc/BRIEF.md
# Runahead Store-to-Load Cache

This block is a small direct-mapped cache used only while the core runs speculatively past a long-latency miss. Stores that pseudo-retire in that mode write their bytes into it, together with a per-byte invalid-result flag. Later speculative loads look it up, in the same cycle as the store buffer and the L1 data cache, so that they can see the values and the poisoned status left by earlier speculative stores. It never writes anything back to memory and is never filled on a miss. A miss only tells the load to take its data from the other structures. When the speculative mode ends, every line is dropped in a single clock.

Storage is 64 lines of 8 bytes, which is 512 data bytes. Each line holds a tag and a valid bit. Each byte holds a written bit and an INV bit. Addresses on both ports are line addresses, and byte enables select the bytes inside the line. The low `$clog2(NUM_LINES)` bits pick the line and the remaining bits form the tag.

A two-state controller tracks the mode. `RA_NORMAL` is the state after reset and while `runahead_i` is low. `RA_ACTIVE` is the state while the cache accepts accesses. There are three transitions. ENTER goes from `RA_NORMAL` to `RA_ACTIVE` when `runahead_i` is high. HOLD keeps `RA_ACTIVE` while `runahead_i` stays high. EXIT goes from `RA_ACTIVE` to `RA_NORMAL` when `runahead_i` is low, and this edge clears every line valid bit. Accesses take effect only when the state is `RA_ACTIVE` and `runahead_i` is high in the same cycle.

Top module: `ra_stcache`

## Requirements
- R1: After reset, `ld_hit_o`, `ld_inv_o` and `ld_data_o` are zero and no line is valid.
- R2: A load whose selected bytes were all written by earlier stores to the same line address returns `ld_hit_o`=1 and those bytes in their lanes (byte b in bits 8b+7:8b), one cycle after the request.
- R3: `ld_inv_o` is 1 on a hit only if at least one selected byte carries INV. Bytes that are not selected do not affect it.
- R4: A load misses (`ld_hit_o`=0) if any selected byte is unwritten, or if the line is invalid or holds another tag.
- R5: A store whose line index matches but whose tag differs replaces the line. The bytes it did not write become unwritten, so the old tag misses.
- R6: A store to a line with a matching tag merges its bytes into the line. Each written byte takes the new data and the store's INV flag, and the other bytes keep their data and INV bits.
- R7: When a load and a store address the same line in one cycle, the load reports the state from before the store.
- R8: The EXIT transition flushes all lines, so after re-entry every earlier address misses.
- R9: Stores and loads are ignored while the state is `RA_NORMAL`. An ignored load returns hit 0.
- R10: `ld_data_o` is zero in unselected lanes and fully zero on a miss. `ld_inv_o` is 0 on a miss.
- R11: A load with all byte enables zero never hits.
- R12: Outputs are registered. `ld_hit_o` is 1 only in the cycle after an accepted load request.
- R13: Accesses in the ENTER cycle and in the EXIT cycle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| runahead_i | input | 1 | Speculative mode level from the core |
| st_valid_i | input | 1 | Pseudo-retiring store present |
| st_laddr_i | input | LADDR_W | Store line address |
| st_data_i | input | 8*LINE_BYTES | Store data, byte b in lane b |
| st_be_i | input | LINE_BYTES | Store byte enables |
| st_inv_i | input | 1 | Store result is invalid (INV) |
| ld_valid_i | input | 1 | Speculative load lookup request |
| ld_laddr_i | input | LADDR_W | Load line address |
| ld_be_i | input | LINE_BYTES | Load byte enables |
| ld_hit_o | output | 1 | All selected bytes present |
| ld_data_o | output | 8*LINE_BYTES | Selected bytes, zero elsewhere |
| ld_inv_o | output | 1 | Some selected byte is INV |

## Verification
The bench builds the block with its default parameters: 64 lines of 8 bytes and a 29-bit line address. With these values, line addresses 8 and 72 share index 8 and differ only in tag, so the replacement rule can be reached with two addresses. Line address 32 provides an unrelated index. The stimulus table covers partial-byte merges, mixed INV bytes within a line, and a load and a store to the same line in one cycle. Directed steps cover the ENTER and EXIT cycles and the flush.

// File: rtl/ra_stcache_pkg.sv
package ra_stcache_pkg;

    typedef enum logic [0:0] {
        RA_NORMAL = 1'b0,
        RA_ACTIVE = 1'b1
    } ra_state_e;

endpackage

// File: rtl/ra_mode_fsm.sv
module ra_mode_fsm
    import ra_stcache_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_i,
    output logic acc_en_o,
    output logic flush_o
);

    ra_state_e state_q;
    ra_state_e state_d;

    // Next-state logic: ENTER, HOLD and EXIT.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RA_NORMAL: if (mode_i)  state_d = RA_ACTIVE;   // ENTER
            RA_ACTIVE: if (!mode_i) state_d = RA_NORMAL;   // EXIT, otherwise HOLD
            default:   state_d = RA_NORMAL;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RA_NORMAL;
        else        state_q <= state_d;
    end

    // Output logic.
    always_comb begin
        acc_en_o = 1'b0;
        flush_o  = 1'b0;
        unique case (state_q)
            RA_NORMAL: ;
            RA_ACTIVE: begin
                acc_en_o = mode_i;
                flush_o  = !mode_i;
            end
            default: ;
        endcase
    end

    // R13: the active state is only reached after the mode input was high.
    assert_active_after_mode_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RA_ACTIVE) |-> $past(mode_i));

    // R8: the flush cycle returns the controller to the normal state.
    assert_exit_to_normal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> (state_q == RA_NORMAL));

endmodule

// File: rtl/ra_line_store.sv
module ra_line_store #(
    parameter int NUM_LINES  = 64,
    parameter int LINE_BYTES = 8,
    parameter int TAG_W      = 23,
    localparam int IDX_W     = $clog2(NUM_LINES),
    localparam int DATA_W    = 8 * LINE_BYTES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush_i,
    input  logic                  wr_en_i,
    input  logic [IDX_W-1:0]      wr_idx_i,
    input  logic [TAG_W-1:0]      wr_tag_i,
    input  logic [DATA_W-1:0]     wr_data_i,
    input  logic [LINE_BYTES-1:0] wr_be_i,
    input  logic                  wr_inv_i,
    input  logic [IDX_W-1:0]      rd_idx_i,
    output logic                  rd_valid_o,
    output logic [TAG_W-1:0]      rd_tag_o,
    output logic [LINE_BYTES-1:0] rd_written_o,
    output logic [LINE_BYTES-1:0] rd_inv_o,
    output logic [DATA_W-1:0]     rd_data_o
);

    logic [NUM_LINES-1:0]  valid_q;
    logic [TAG_W-1:0]      tag_q     [NUM_LINES];
    logic [LINE_BYTES-1:0] written_q [NUM_LINES];
    logic [LINE_BYTES-1:0] inv_q     [NUM_LINES];
    logic [DATA_W-1:0]     data_q    [NUM_LINES];

    logic                  same_line;
    logic [LINE_BYTES-1:0] new_written;
    logic [LINE_BYTES-1:0] new_inv;
    logic [DATA_W-1:0]     new_data;

    assign same_line = valid_q[wr_idx_i] && (tag_q[wr_idx_i] == wr_tag_i);

    // Merge into a matching line, or start a fresh line on a tag conflict.
    always_comb begin
        if (same_line) begin
            new_written = written_q[wr_idx_i] | wr_be_i;
            new_inv     = (inv_q[wr_idx_i] & ~wr_be_i) | (wr_be_i & {LINE_BYTES{wr_inv_i}});
        end else begin
            new_written = wr_be_i;
            new_inv     = wr_be_i & {LINE_BYTES{wr_inv_i}};
        end
        for (int b = 0; b < LINE_BYTES; b++) begin
            if (wr_be_i[b])
                new_data[b*8 +: 8] = wr_data_i[b*8 +: 8];
            else if (same_line)
                new_data[b*8 +: 8] = data_q[wr_idx_i][b*8 +: 8];
            else
                new_data[b*8 +: 8] = 8'h00;
        end
    end

    // Line valid bits: cleared together on flush.
    always_ff @(posedge clk) begin
        if (!rst_n)       valid_q <= '0;
        else if (flush_i) valid_q <= '0;
        else if (wr_en_i) valid_q[wr_idx_i] <= 1'b1;
    end

    // Line contents.
    always_ff @(posedge clk) begin
        if (wr_en_i && !flush_i) begin
            tag_q[wr_idx_i]     <= wr_tag_i;
            written_q[wr_idx_i] <= new_written;
            inv_q[wr_idx_i]     <= new_inv;
            data_q[wr_idx_i]    <= new_data;
        end
    end

    // The read view is taken before this cycle's write.
    assign rd_valid_o   = valid_q[rd_idx_i];
    assign rd_tag_o     = tag_q[rd_idx_i];
    assign rd_written_o = written_q[rd_idx_i];
    assign rd_inv_o     = inv_q[rd_idx_i];
    assign rd_data_o    = data_q[rd_idx_i];

    assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (valid_q == '0));

    assert_write_sets_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !flush_i) |=> valid_q[$past(wr_idx_i)]);

endmodule

// File: rtl/ra_lookup.sv
module ra_lookup #(
    parameter int LINE_BYTES = 8,
    parameter int TAG_W      = 23,
    localparam int DATA_W    = 8 * LINE_BYTES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_i,
    input  logic [TAG_W-1:0]      tag_i,
    input  logic [LINE_BYTES-1:0] be_i,
    input  logic                  line_valid_i,
    input  logic [TAG_W-1:0]      line_tag_i,
    input  logic [LINE_BYTES-1:0] line_written_i,
    input  logic [LINE_BYTES-1:0] line_inv_i,
    input  logic [DATA_W-1:0]     line_data_i,
    output logic                  hit_o,
    output logic                  inv_o,
    output logic [DATA_W-1:0]     data_o
);

    logic              covered;
    logic              hit_d;
    logic              inv_d;
    logic [DATA_W-1:0] data_d;

    assign covered = (be_i != '0) && ((be_i & ~line_written_i) == '0);
    assign hit_d   = req_i && line_valid_i && (line_tag_i == tag_i) && covered;
    assign inv_d   = hit_d && ((be_i & line_inv_i) != '0);

    always_comb begin
        for (int b = 0; b < LINE_BYTES; b++)
            data_d[b*8 +: 8] = (hit_d && be_i[b]) ? line_data_i[b*8 +: 8] : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_o  <= 1'b0;
            inv_o  <= 1'b0;
            data_o <= '0;
        end else begin
            hit_o  <= hit_d;
            inv_o  <= inv_d;
            data_o <= data_d;
        end
    end

    assert_hit_needs_request_R12: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> $past(req_i));

    assert_miss_is_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (!inv_o && (data_o == '0)));

    assert_empty_mask_misses_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> ($past(be_i) != '0));

endmodule

// File: rtl/ra_stcache.sv
module ra_stcache #(
    parameter int NUM_LINES  = 64,
    parameter int LINE_BYTES = 8,
    parameter int LADDR_W    = 29,
    localparam int IDX_W     = $clog2(NUM_LINES),
    localparam int TAG_W     = LADDR_W - IDX_W,
    localparam int DATA_W    = 8 * LINE_BYTES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  runahead_i,
    input  logic                  st_valid_i,
    input  logic [LADDR_W-1:0]    st_laddr_i,
    input  logic [DATA_W-1:0]     st_data_i,
    input  logic [LINE_BYTES-1:0] st_be_i,
    input  logic                  st_inv_i,
    input  logic                  ld_valid_i,
    input  logic [LADDR_W-1:0]    ld_laddr_i,
    input  logic [LINE_BYTES-1:0] ld_be_i,
    output logic                  ld_hit_o,
    output logic [DATA_W-1:0]     ld_data_o,
    output logic                  ld_inv_o
);

    logic                  acc_en;
    logic                  flush;
    logic                  wr_en;
    logic                  rd_valid;
    logic [TAG_W-1:0]      rd_tag;
    logic [LINE_BYTES-1:0] rd_written;
    logic [LINE_BYTES-1:0] rd_inv;
    logic [DATA_W-1:0]     rd_data;

    assign wr_en = acc_en && st_valid_i && (st_be_i != '0);

    ra_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (runahead_i),
        .acc_en_o (acc_en),
        .flush_o  (flush)
    );

    ra_line_store #(
        .NUM_LINES  (NUM_LINES),
        .LINE_BYTES (LINE_BYTES),
        .TAG_W      (TAG_W)
    ) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (flush),
        .wr_en_i      (wr_en),
        .wr_idx_i     (st_laddr_i[IDX_W-1:0]),
        .wr_tag_i     (st_laddr_i[LADDR_W-1:IDX_W]),
        .wr_data_i    (st_data_i),
        .wr_be_i      (st_be_i),
        .wr_inv_i     (st_inv_i),
        .rd_idx_i     (ld_laddr_i[IDX_W-1:0]),
        .rd_valid_o   (rd_valid),
        .rd_tag_o     (rd_tag),
        .rd_written_o (rd_written),
        .rd_inv_o     (rd_inv),
        .rd_data_o    (rd_data)
    );

    ra_lookup #(
        .LINE_BYTES (LINE_BYTES),
        .TAG_W      (TAG_W)
    ) u_lookup (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_i          (acc_en && ld_valid_i),
        .tag_i          (ld_laddr_i[LADDR_W-1:IDX_W]),
        .be_i           (ld_be_i),
        .line_valid_i   (rd_valid),
        .line_tag_i     (rd_tag),
        .line_written_i (rd_written),
        .line_inv_i     (rd_inv),
        .line_data_i    (rd_data),
        .hit_o          (ld_hit_o),
        .inv_o          (ld_inv_o),
        .data_o         (ld_data_o)
    );

    // R9: a hit never follows a load made with the mode input low.
    assert_no_hit_outside_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_hit_o |-> $past(runahead_i && ld_valid_i));

    // R3: INV is only reported together with a hit.
    assert_inv_with_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_inv_o |-> ld_hit_o);

endmodule

// File: tb/ra_stcache_bench.sv
module ra_stcache_bench;

    typedef struct packed {
        logic        st;
        logic        ld;
        logic [28:0] la;
        logic [63:0] sd;
        logic [7:0]  sbe;
        logic        sinv;
        logic [7:0]  lbe;
        logic        eh;
        logic [63:0] ed;
        logic        ei;
        logic [3:0]  rq;
    } vec_t;

    localparam logic [28:0] LA = 29'd8;   // index 8, tag 0
    localparam logic [28:0] LB = 29'd72;  // index 8, tag 1
    localparam logic [28:0] LC = 29'd32;  // index 32
    localparam int NV = 19;

    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b0,LA,64'h1122334455667788,8'h0F,1'b0,8'h00,1'b0,64'h0,1'b0,4'd12}, // R12
        '{1'b0,1'b1,LA,64'h0,8'h00,1'b0,8'h0F,1'b1,64'h0000000055667788,1'b0,4'd2},  // R2 R10
        '{1'b0,1'b1,LA,64'h0,8'h00,1'b0,8'h1F,1'b0,64'h0,1'b0,4'd4},                 // R4
        '{1'b1,1'b0,LA,64'hAABBCCDD00000000,8'hF0,1'b1,8'h00,1'b0,64'h0,1'b0,4'd12}, // R12
        '{1'b0,1'b1,LA,64'h0,8'h00,1'b0,8'hFF,1'b1,64'hAABBCCDD55667788,1'b1,4'd6},  // R6
        '{1'b0,1'b1,LA,64'h0,8'h00,1'b0,8'h03,1'b1,64'h0000000000007788,1'b0,4'd3},  // R3
        '{1'b1,1'b0,LA,64'h9900000000000000,8'h80,1'b0,8'h00,1'b0,64'h0,1'b0,4'd12}, // R12
        '{1'b0,1'b1,LA,64'h0,8'h00,1'b0,8'hF0,1'b1,64'h99BBCCDD00000000,1'b1,4'd6},  // R6
        '{1'b0,1'b1,LA,64'h0,8'h00,1'b0,8'h80,1'b1,64'h9900000000000000,1'b0,4'd3},  // R3
        '{1'b1,1'b0,LB,64'h0102030405060708,8'h01,1'b0,8'h00,1'b0,64'h0,1'b0,4'd5},  // R5
        '{1'b0,1'b1,LA,64'h0,8'h00,1'b0,8'h01,1'b0,64'h0,1'b0,4'd5},                 // R5
        '{1'b0,1'b1,LB,64'h0,8'h00,1'b0,8'h01,1'b1,64'h0000000000000008,1'b0,4'd5},  // R5
        '{1'b0,1'b1,LB,64'h0,8'h00,1'b0,8'h02,1'b0,64'h0,1'b0,4'd5},                 // R5
        '{1'b0,1'b1,LC,64'h0,8'h00,1'b0,8'h01,1'b0,64'h0,1'b0,4'd4},                 // R4
        '{1'b0,1'b1,LB,64'h0,8'h00,1'b0,8'h00,1'b0,64'h0,1'b0,4'd11},                // R11
        '{1'b1,1'b1,LC,64'h00000000000000FF,8'h01,1'b0,8'h01,1'b0,64'h0,1'b0,4'd7},  // R7
        '{1'b0,1'b1,LC,64'h0,8'h00,1'b0,8'h01,1'b1,64'h00000000000000FF,1'b0,4'd7},  // R7
        '{1'b1,1'b1,LB,64'h0000000000000055,8'h01,1'b0,8'h01,1'b1,64'h0000000000000008,1'b0,4'd7}, // R7
        '{1'b0,1'b1,LB,64'h0,8'h00,1'b0,8'h01,1'b1,64'h0000000000000055,1'b0,4'd7}   // R7
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        runahead_i;
    logic        st_valid_i;
    logic [28:0] st_laddr_i;
    logic [63:0] st_data_i;
    logic [7:0]  st_be_i;
    logic        st_inv_i;
    logic        ld_valid_i;
    logic [28:0] ld_laddr_i;
    logic [7:0]  ld_be_i;
    logic        ld_hit_o;
    logic [63:0] ld_data_o;
    logic        ld_inv_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    ra_stcache u_ra_stcache (
        .clk        (clk),
        .rst_n      (rst_n),
        .runahead_i (runahead_i),
        .st_valid_i (st_valid_i),
        .st_laddr_i (st_laddr_i),
        .st_data_i  (st_data_i),
        .st_be_i    (st_be_i),
        .st_inv_i   (st_inv_i),
        .ld_valid_i (ld_valid_i),
        .ld_laddr_i (ld_laddr_i),
        .ld_be_i    (ld_be_i),
        .ld_hit_o   (ld_hit_o),
        .ld_data_o  (ld_data_o),
        .ld_inv_o   (ld_inv_o)
    );

    task automatic drive(input logic st, input logic ld, input logic [28:0] la,
                         input logic [63:0] sd, input logic [7:0] sbe,
                         input logic sinv, input logic [7:0] lbe);
        @(negedge clk);
        st_valid_i = st;  st_laddr_i = la; st_data_i = sd; st_be_i = sbe; st_inv_i = sinv;
        ld_valid_i = ld;  ld_laddr_i = la; ld_be_i = lbe;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string rq, input logic eh, input logic [63:0] ed, input logic ei);
        n_cmp++;
        if (ld_hit_o !== eh || ld_data_o !== ed || ld_inv_o !== ei) begin
            n_bad++;
            $display("FAIL %s: hit/data/inv got %b/%h/%b expected %b/%h/%b",
                     rq, ld_hit_o, ld_data_o, ld_inv_o, eh, ed, ei);
        end
    endtask

    initial begin
        rst_n = 1'b0; runahead_i = 1'b0;
        st_valid_i = 1'b0; st_laddr_i = '0; st_data_i = '0; st_be_i = '0; st_inv_i = 1'b0;
        ld_valid_i = 1'b0; ld_laddr_i = '0; ld_be_i = '0;
        repeat (3) step();
        check("R1 reset outputs", 1'b0, 64'h0, 1'b0);
        @(negedge clk); rst_n = 1'b1;

        // R9: store and load in normal mode are ignored
        drive(1'b1, 1'b0, LA, 64'hFFFFFFFFFFFFFFFF, 8'hFF, 1'b0, 8'h00); step();
        drive(1'b0, 1'b1, LA, 64'h0, 8'h00, 1'b0, 8'hFF); step();
        check("R9 load in normal mode", 1'b0, 64'h0, 1'b0);

        // R13: store in the ENTER cycle is dropped
        drive(1'b1, 1'b0, LC, 64'h00000000000000AA, 8'h01, 1'b0, 8'h00);
        runahead_i = 1'b1; step();
        drive(1'b0, 1'b1, LA, 64'h0, 8'h00, 1'b0, 8'hFF); step();
        check("R9 normal-mode store left no line", 1'b0, 64'h0, 1'b0);
        drive(1'b0, 1'b1, LC, 64'h0, 8'h00, 1'b0, 8'h01); step();
        check("R13 enter-cycle store dropped", 1'b0, 64'h0, 1'b0);
        // R1: nothing is valid after reset either
        drive(1'b0, 1'b1, LB, 64'h0, 8'h00, 1'b0, 8'h01); step();
        check("R1 no valid line after reset", 1'b0, 64'h0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].st, VEC[i].ld, VEC[i].la, VEC[i].sd, VEC[i].sbe, VEC[i].sinv, VEC[i].lbe);
            step();
            check($sformatf("R%0d vector %0d", VEC[i].rq, i), VEC[i].eh, VEC[i].ed, VEC[i].ei);
        end

        // R12: result appears only after the clock edge
        drive(1'b0, 1'b0, LB, 64'h0, 8'h00, 1'b0, 8'h00); step();
        check("R12 idle cycle", 1'b0, 64'h0, 1'b0);
        drive(1'b0, 1'b1, LB, 64'h0, 8'h00, 1'b0, 8'h01); #2;
        check("R12 before edge", 1'b0, 64'h0, 1'b0);
        step();
        check("R12 after edge", 1'b1, 64'h0000000000000055, 1'b0);

        // R8 and R13: EXIT cycle with a store, then re-enter
        drive(1'b1, 1'b0, 29'd40, 64'h0000000000000077, 8'h01, 1'b0, 8'h00);
        runahead_i = 1'b0; step();
        drive(1'b0, 1'b0, LA, 64'h0, 8'h00, 1'b0, 8'h00);
        runahead_i = 1'b1; step();
        drive(1'b0, 1'b1, LA, 64'h0, 8'h00, 1'b0, 8'h80); step();
        check("R8 flushed line A", 1'b0, 64'h0, 1'b0);
        drive(1'b0, 1'b1, LB, 64'h0, 8'h00, 1'b0, 8'h01); step();
        check("R8 flushed line B", 1'b0, 64'h0, 1'b0);
        drive(1'b0, 1'b1, 29'd40, 64'h0, 8'h00, 1'b0, 8'h01); step();
        check("R13 exit-cycle store dropped", 1'b0, 64'h0, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, got hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule